// File: doc/BRIEF.md
# Sync Timing Meter with Interlace Detection

This block runs on a fixed 13.5 MHz reference clock. It takes horizontal and vertical sync pulses that have already been separated from the video and are synchronous to that clock. Every vertical edge produces a new set of results:

- the line period and the horizontal pulse width, both counted in reference cycles;
- the field period;
- the number of lines per frame;
- whether the signal is interlaced.

It also reports:

- flags for frames of 525 and 625 lines, each with a tolerance;
- a flag for spurious horizontal pulses inside a line;
- a stability flag;
- a no-signal flag for when either sync stops.

A format-recognition controller reads the results as static status words. They hold their values between vertical edges. A horizontal pulse that arrives less than three quarters of a line period after the last accepted pulse is treated as an extra pulse. An extra pulse is excluded from every measurement. When the vertical edge falls about half a line away from where it fell on the previous field, and this happens on two fields in a row, the source is classed as interlaced. For an interlaced source, the lines of the last two fields are added together to give the lines per frame.

Top module: `sync_timing_meter`

## Requirements
- R1: `line_period_o` holds the number of reference cycles between the last two accepted rising edges of `hsync_i`. The first accepted edge after reset, or after a horizontal no-signal condition, only starts the count.
- R2: `hs_width_o` holds the number of cycles that `hsync_i` stayed high during the last accepted pulse. It is updated when that pulse falls.
- R3: `field_period_o` holds the number of cycles between the last two rising edges of `vsync_i`.
- R4: `lines_per_frame_o` holds the number of accepted horizontal rising edges in the field that just ended. While the source is classed as interlaced, it holds the sum of the counts for the last two fields.
- R5: `interlaced_o` is set at a vertical edge when both this edge and the previous one satisfy a phase condition. The phase is the number of cycles since the last accepted horizontal edge. The condition is that the phase differs from the previous field's phase by more than a quarter and less than three quarters of `line_period_o`. Otherwise the flag is cleared.
- R6: `std525_o` is set when the lines per frame lie in 523..527, and `std625_o` is set when they lie in 623..627. The two flags are never set together.
- R7: A horizontal rising edge that comes less than three quarters of the line period after the last accepted edge changes no measurement. `extra_sync_o` reports at each vertical edge whether the field that just ended contained such a pulse.
- R8: `no_signal_o` is set when the horizontal counter reaches its maximum without an edge, or when the vertical counter does so. It clears on the next edge of the missing sync. While it is set, `stable_o` is cleared one cycle later.
- R9: `stable_o` is set at a vertical edge when at least two earlier vertical edges have been seen, the new lines-per-frame value equals the previous one, and no-signal is clear.
- R10: Every output is zero after reset. `field_period_o`, `lines_per_frame_o`, `interlaced_o`, the standard flags, `extra_sync_o` and `stable_o` change only in the cycle after a detected vertical rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 13.5 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Separated horizontal sync, active high |
| vsync_i | input | 1 | Separated vertical sync, active high |
| line_period_o | output | LINE_W | Line period in reference cycles |
| hs_width_o | output | WIDTH_W | Horizontal pulse width in reference cycles |
| field_period_o | output | FRAME_W | Field period in reference cycles |
| lines_per_frame_o | output | LCNT_W+1 | Measured lines per frame |
| interlaced_o | output | 1 | Interlaced source detected |
| std525_o | output | 1 | Frame within 2 lines of 525 |
| std625_o | output | 1 | Frame within 2 lines of 625 |
| extra_sync_o | output | 1 | Extra horizontal pulses in the last field |
| no_signal_o | output | 1 | A sync counter saturated |
| stable_o | output | 1 | Two consecutive matching frames |

## Verification
The assertions check several properties on every cycle:

- line period and pulse width change only after an accepted edge and a falling edge respectively;
- the frame results and flags change only after a vertical edge;
- the two standard flags are never set together;
- stability drops once no-signal is raised.

Only the directed scenarios can show the numbers themselves. These scenarios cover:

- the measured periods and widths under two line timings;
- the half-line field offset that produces 525 lines and the interlace flag;
- the tolerance edges at 522/523 and 627/628 lines;
- an extra pulse being ignored and then reported;
- the saturation that raises no-signal.

// File: rtl/sync_meas_pkg.sv
package sync_meas_pkg;
  localparam int unsigned LINES_525 = 525;
  localparam int unsigned LINES_625 = 625;

  function automatic logic within_tol(input int unsigned val, input int unsigned target,
                                      input int unsigned tol);
    return (val + tol >= target) && (val <= target + tol);
  endfunction
endpackage

// File: rtl/sync_line_meas.sv
module sync_line_meas #(
  parameter int LINE_W  = 12,
  parameter int WIDTH_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hsync_i,
  output logic [LINE_W-1:0]  period_o,
  output logic [LINE_W-1:0]  phase_o,
  output logic [WIDTH_W-1:0] width_o,
  output logic               acc_o,
  output logic               extra_o,
  output logic               sat_o
);
  localparam logic [LINE_W-1:0]  CNT_MAX = {LINE_W{1'b1}};
  localparam logic [WIDTH_W-1:0] W_MAX   = {WIDTH_W{1'b1}};

  logic               hs_q, rise, fall;
  logic [LINE_W-1:0]  h_cnt, thresh;
  logic [WIDTH_W-1:0] w_cnt;
  logic               armed, lp_valid, in_pulse;

  assign rise    = hsync_i & ~hs_q;
  assign fall    = ~hsync_i & hs_q;
  assign thresh  = period_o - (period_o >> 2);
  assign extra_o = rise && lp_valid && (h_cnt < thresh);
  assign acc_o   = rise && !extra_o;
  assign phase_o = h_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= 1'b0; h_cnt <= '0; period_o <= '0; width_o <= '0; w_cnt <= '0;
      armed <= 1'b0; lp_valid <= 1'b0; in_pulse <= 1'b0; sat_o <= 1'b0;
    end else begin
      hs_q <= hsync_i;
      if (acc_o) begin
        if (armed && !sat_o) begin
          period_o <= h_cnt;
          lp_valid <= 1'b1;
        end
        armed    <= 1'b1;
        h_cnt    <= LINE_W'(1);
        sat_o    <= 1'b0;
        w_cnt    <= WIDTH_W'(1);
        in_pulse <= 1'b1;
      end else begin
        if (h_cnt == CNT_MAX) begin
          sat_o    <= 1'b1;
          armed    <= 1'b0;
          lp_valid <= 1'b0;
        end else begin
          h_cnt <= h_cnt + 1'b1;
        end
        if (in_pulse) begin
          if (fall) begin
            width_o  <= w_cnt;
            in_pulse <= 1'b0;
          end else if (w_cnt != W_MAX) begin
            w_cnt <= w_cnt + 1'b1;
          end
        end
      end
    end
  end

  p_period_on_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(period_o) |-> $past(acc_o));
  p_width_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(width_o) |-> $past(fall));
endmodule

// File: rtl/sync_field_meas.sv
module sync_field_meas
  import sync_meas_pkg::*;
#(
  parameter int          LINE_W  = 12,
  parameter int          FRAME_W = 22,
  parameter int          LCNT_W  = 11,
  parameter int unsigned TOL     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic              acc_i,
  input  logic              extra_i,
  input  logic              h_sat_i,
  input  logic [LINE_W-1:0] phase_i,
  input  logic [LINE_W-1:0] period_i,
  output logic [FRAME_W-1:0] field_period_o,
  output logic [LCNT_W:0]   lines_o,
  output logic              interlaced_o,
  output logic              std525_o,
  output logic              std625_o,
  output logic              extra_o,
  output logic              stable_o,
  output logic              v_sat_o
);
  localparam logic [FRAME_W-1:0] V_MAX = {FRAME_W{1'b1}};
  localparam logic [LCNT_W-1:0]  L_MAX = {LCNT_W{1'b1}};

  logic               vs_q, vs_rise;
  logic [FRAME_W-1:0] v_cnt;
  logic [LCNT_W-1:0]  l_cnt, prev_lines;
  logic [LINE_W-1:0]  prev_phase, phase_eff, diff, quarter;
  logic [1:0]         fld_cnt;
  logic               il_evt_q, extra_seen, evt, il_next, stable_next;
  logic [LCNT_W:0]    lpf_next;

  assign vs_rise   = vsync_i & ~vs_q;
  assign phase_eff = acc_i ? '0 : phase_i;
  assign diff      = (phase_eff >= prev_phase) ? phase_eff - prev_phase : prev_phase - phase_eff;
  assign quarter   = period_i >> 2;
  // half-line shift of the vertical edge relative to the previous field
  assign evt       = (fld_cnt != 2'd0) && (period_i != '0) &&
                     (diff > quarter) && (diff < period_i - quarter);
  assign il_next   = evt && il_evt_q;
  assign lpf_next  = il_next ? {1'b0, prev_lines} + {1'b0, l_cnt} : {1'b0, l_cnt};
  assign stable_next = fld_cnt[1] && (lpf_next == lines_o) && !h_sat_i && !v_sat_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q <= 1'b0; v_cnt <= '0; l_cnt <= '0; prev_lines <= '0; prev_phase <= '0;
      fld_cnt <= '0; il_evt_q <= 1'b0; extra_seen <= 1'b0; v_sat_o <= 1'b0;
      field_period_o <= '0; lines_o <= '0; interlaced_o <= 1'b0; std525_o <= 1'b0;
      std625_o <= 1'b0; extra_o <= 1'b0; stable_o <= 1'b0;
    end else begin
      vs_q <= vsync_i;
      if (vs_rise) begin
        field_period_o <= v_cnt;
        v_cnt          <= FRAME_W'(1);
        v_sat_o        <= 1'b0;
        lines_o        <= lpf_next;
        interlaced_o   <= il_next;
        std525_o       <= within_tol(32'(lpf_next), LINES_525, TOL);
        std625_o       <= within_tol(32'(lpf_next), LINES_625, TOL);
        extra_o        <= extra_seen || extra_i;
        extra_seen     <= 1'b0;
        stable_o       <= stable_next;
        prev_lines     <= l_cnt;
        prev_phase     <= phase_eff;
        il_evt_q       <= evt;
        l_cnt          <= acc_i ? LCNT_W'(1) : '0;
        if (fld_cnt != 2'd3) fld_cnt <= fld_cnt + 1'b1;
      end else begin
        if (v_cnt == V_MAX) v_sat_o <= 1'b1;
        else                v_cnt   <= v_cnt + 1'b1;
        if (acc_i && l_cnt != L_MAX) l_cnt <= l_cnt + 1'b1;
        if (extra_i) extra_seen <= 1'b1;
      end
      if (h_sat_i || v_sat_o) stable_o <= 1'b0;
    end
  end

  p_lines_on_vs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lines_o) |-> $past(vs_rise));
  p_il_on_vs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(interlaced_o) |-> $past(vs_rise));
  p_extra_on_vs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(extra_o) |-> $past(vs_rise));
  p_std_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(std525_o && std625_o));
  p_nosig_unstable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_sat_i || v_sat_o) |=> !stable_o);
endmodule

// File: rtl/sync_timing_meter.sv
module sync_timing_meter #(
  parameter int          LINE_W  = 12,
  parameter int          WIDTH_W = 10,
  parameter int          FRAME_W = 22,
  parameter int          LCNT_W  = 11,
  parameter int unsigned TOL     = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hsync_i,
  input  logic               vsync_i,
  output logic [LINE_W-1:0]  line_period_o,
  output logic [WIDTH_W-1:0] hs_width_o,
  output logic [FRAME_W-1:0] field_period_o,
  output logic [LCNT_W:0]    lines_per_frame_o,
  output logic               interlaced_o,
  output logic               std525_o,
  output logic               std625_o,
  output logic               extra_sync_o,
  output logic               no_signal_o,
  output logic               stable_o
);
  logic [LINE_W-1:0] phase;
  logic              acc, extra, h_sat, v_sat;

  sync_line_meas #(.LINE_W(LINE_W), .WIDTH_W(WIDTH_W)) u_line (
    .clk_i, .rst_ni, .hsync_i,
    .period_o(line_period_o), .phase_o(phase), .width_o(hs_width_o),
    .acc_o(acc), .extra_o(extra), .sat_o(h_sat)
  );

  sync_field_meas #(.LINE_W(LINE_W), .FRAME_W(FRAME_W), .LCNT_W(LCNT_W), .TOL(TOL)) u_field (
    .clk_i, .rst_ni, .vsync_i,
    .acc_i(acc), .extra_i(extra), .h_sat_i(h_sat), .phase_i(phase), .period_i(line_period_o),
    .field_period_o, .lines_o(lines_per_frame_o), .interlaced_o, .std525_o, .std625_o,
    .extra_o(extra_sync_o), .stable_o, .v_sat_o(v_sat)
  );

  assign no_signal_o = h_sat | v_sat;
endmodule

// File: tb/sync_timing_meter_tb_top.sv
module sync_timing_meter_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hsync = 1'b0, vsync = 1'b0;
  logic [11:0] line_period, lines_pf;
  logic [9:0]  hs_width;
  logic [21:0] field_period;
  logic        interlaced, std525, std625, extra_sync, no_signal, stable;
  int          nchk = 0, nerr = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sync_timing_meter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hsync_i(hsync), .vsync_i(vsync),
    .line_period_o(line_period), .hs_width_o(hs_width), .field_period_o(field_period),
    .lines_per_frame_o(lines_pf), .interlaced_o(interlaced), .std525_o(std525),
    .std625_o(std625), .extra_sync_o(extra_sync), .no_signal_o(no_signal), .stable_o(stable)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_ni = 1'b0; hsync = 1'b0; vsync = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // one line: hs pulse at start, optional vs pulse and extra hs pulse at given phases
  task automatic run_line(input int len, input int hsw, input int vs_ph, input int x_ph);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      hsync = (c < hsw) || (x_ph >= 0 && c >= x_ph && c < x_ph + 2);
      vsync = (vs_ph >= 0 && c >= vs_ph && c < vs_ph + 2);
    end
  endtask

  task automatic run_frame(input int n, input int len, input int hsw, input int x_line);
    for (int l = 0; l < n; l++)
      run_line(len, hsw, (l == 0) ? 3 : -1, (l == x_line) ? 8 : -1);
  endtask

  task automatic run_il_frame();
    for (int l = 0; l < 525; l++)
      run_line(20, 4, (l == 0) ? 3 : ((l == 262) ? 13 : -1), -1);
  endtask

  task automatic t_reset();
    apply_reset();
    chk("R10 line_period", line_period, 0);
    chk("R10 hs_width", hs_width, 0);
    chk("R10 field_period", field_period, 0);
    chk("R10 lines", lines_pf, 0);
    chk("R10 flags", {interlaced, std525, std625, extra_sync, no_signal, stable}, 0);
  endtask

  task automatic t_progressive(input int n, input int len, input int hsw);
    apply_reset();
    run_frame(n, len, hsw, -1);
    run_frame(n, len, hsw, -1);
    chk("R9 not yet stable", stable, 0);
    run_frame(n, len, hsw, -1);
    chk("R1 line period", line_period, len);
    chk("R2 hs width", hs_width, hsw);
    chk("R3 field period", field_period, n * len);
    chk("R4 lines per frame", lines_pf, n);
    chk("R5 progressive", interlaced, 0);
    chk("R6 no standard", {std525, std625}, 0);
    chk("R7 no extra", extra_sync, 0);
    chk("R8 signal present", no_signal, 0);
    chk("R9 stable", stable, 1);
  endtask

  task automatic t_extra();
    apply_reset();
    run_frame(100, 20, 4, -1);
    run_frame(100, 20, 4, -1);
    run_frame(100, 20, 4, 40);
    run_frame(100, 20, 4, -1);
    chk("R7 extra reported", extra_sync, 1);
    chk("R7 period unaffected", line_period, 20);
    chk("R7 width unaffected", hs_width, 4);
    chk("R7 lines unaffected", lines_pf, 100);
    run_line(20, 4, 3, -1);
    chk("R7 extra cleared", extra_sync, 0);
  endtask

  task automatic t_std(input int n, input bit e525, input bit e625);
    apply_reset();
    run_frame(n, 20, 4, -1);
    run_line(20, 4, 3, -1);
    chk("R4 lines", lines_pf, n);
    chk("R6 std525", std525, int'(e525));
    chk("R6 std625", std625, int'(e625));
  endtask

  task automatic t_interlace();
    apply_reset();
    run_il_frame();
    run_il_frame();
    chk("R5 interlaced", interlaced, 1);
    chk("R4 frame lines", lines_pf, 525);
    chk("R6 std525", std525, 1);
    chk("R3 field period", field_period, 5250);
    chk("R9 stable", stable, 1);
    run_frame(100, 20, 4, -1);
    run_frame(100, 20, 4, -1);
    chk("R5 cleared", interlaced, 0);
    chk("R4 progressive lines", lines_pf, 100);
  endtask

  task automatic t_nosig();
    apply_reset();
    for (int f = 0; f < 3; f++) run_frame(100, 20, 4, -1);
    chk("R9 stable before loss", stable, 1);
    repeat (4200) @(negedge clk);
    chk("R8 no signal", no_signal, 1);
    chk("R8 stable dropped", stable, 0);
    run_line(20, 4, -1, -1);
    chk("R8 no signal cleared", no_signal, 0);
  endtask

  initial begin
    t_reset();
    t_progressive(100, 20, 4);
    t_progressive(60, 30, 7);
    t_extra();
    t_std(625, 1'b0, 1'b1);
    t_std(627, 1'b0, 1'b1);
    t_std(628, 1'b0, 1'b0);
    t_std(523, 1'b1, 1'b0);
    t_std(522, 1'b0, 1'b0);
    t_interlace();
    t_nosig();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL R10 watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule